// File: doc/BRIEF.md
# Threshold-Gated Transmit Frame Queue

This block is a single-clock byte queue placed between a packet source and a byte-serial transmit engine. The source pushes bytes through a valid/ready port, with a start marker and an end marker on the first and last byte of each frame. The queue holds back the first byte of a frame until enough bytes are buffered. Once a frame has begun, the queue sends one byte on every cycle, so the transmit side never stalls in the middle of a frame.

Four 6-bit thresholds control the behaviour. Each is loaded through a write-only register port.

- **Low-water level.** When the queue reaches this level in the middle of a frame, and that frame's end byte has not arrived, the frame is cut short. The queue sends an error marker and then silently discards the rest of that frame.
- **High-water level.** When the free space reaches this level, the queue pushes back on the source.
- **Congestion level.** A status flag falls when the fill level reaches this value, as an early warning.
- **Start level.** A frame may begin once the fill level reaches this value. A value of zero instead waits for a whole frame to be stored (store-and-forward).

Back-pressure rules at the input: a byte is taken on every rising edge where `in_valid` and `in_ready` are both high. A byte offered while `in_ready` is low is not taken, and the source must hold it. `in_ready` depends only on the fill level and the high-water threshold, never on `in_valid`. The output side has no ready signal, because the transmit engine takes one byte per cycle whenever `tx_en` is high.

Top module: `txq_thresh_fifo`

## Requirements
- R1: `flag_aempty` is high exactly when the fill level is less than or equal to the low-water threshold (register 0, reset value 8).
- R2: `flag_afull` is high and `in_ready` is low exactly when the free entries (64 minus fill) are less than or equal to the high-water threshold (register 1, reset value 8). A byte offered while `in_ready` is low is not stored.
- R3: `flag_sempty` is high while the fill level is below the congestion threshold (register 2, reset value 48) and low once the level reaches it.
- R4: With a non-zero start threshold (register 3, reset value 16), no frame begins until the fill level reaches that value or a complete frame (end byte stored) is held.
- R5: With the start threshold at zero, a frame begins only after its end byte has been written.
- R6: Once a frame begins, `tx_en` is high on every cycle and carries the frame's bytes in write order, up to and including its end byte.
- R7: If, during a frame, the fill level is at or below the low-water threshold and the frame's end byte is not stored, the queue emits one cycle with `tx_en` and `tx_err` both high. It then discards the remaining bytes of that frame through its end byte, without showing them on the output.
- R8: At least 12 cycles with `tx_en` low separate any two frames. This is exactly 12 when the next frame is already eligible to start.
- R9: A register write takes `cfg_wdata` into the threshold chosen by `cfg_addr`: 0 low-water, 1 high-water, 2 congestion, 3 start.
- R10: A write and a read in the same cycle leave the fill level unchanged, and the queue never overflows or underflows.
- R11: A synchronous high reset empties the queue, drops any frame in progress, clears the complete-frame count and restores all four thresholds to their reset values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Source offers a byte |
| in_data | input | 8 | Offered byte |
| in_sop | input | 1 | Byte is the first of a frame |
| in_eop | input | 1 | Byte is the last of a frame |
| in_ready | output | 1 | Queue accepts a byte this cycle |
| cfg_we | input | 1 | Threshold write strobe |
| cfg_addr | input | 2 | Threshold select (0 low-water, 1 high-water, 2 congestion, 3 start) |
| cfg_wdata | input | 6 | Threshold value |
| tx_data | output | 8 | Byte to the transmit engine |
| tx_en | output | 1 | `tx_data` is valid this cycle |
| tx_err | output | 1 | Current frame is aborted (error marker) |
| flag_aempty | output | 1 | Fill level at or below low-water threshold |
| flag_afull | output | 1 | Free space at or below high-water threshold |
| flag_sempty | output | 1 | Fill level below congestion threshold |

## Verification
The assertions check the following on every cycle:

- pushes and pops stay within the queue bounds;
- a simultaneous push and pop leaves the fill level unchanged;
- an error marker always carries `tx_en` and is followed by a quiet cycle;
- a frame never has a hole before its end byte;
- an end byte is followed by a quiet cycle.

Other behaviours only the bench's scenarios can show:

- the flag levels at each threshold edge;
- a refused write leaving the stored frame one byte shorter;
- the exact cycle a frame may start under each start mode;
- the byte count before an abort;
- that discarded bytes never reach the next frame;
- the exact 12-cycle gap.

// File: rtl/txq_pkg.sv
package txq_pkg;
  typedef enum logic [1:0] {
    RD_IDLE  = 2'd0,
    RD_SEND  = 2'd1,
    RD_DRAIN = 2'd2,
    RD_GAP   = 2'd3
  } rd_state_e;

  localparam logic [1:0] CFG_LOW   = 2'd0;
  localparam logic [1:0] CFG_HIGH  = 2'd1;
  localparam logic [1:0] CFG_CONG  = 2'd2;
  localparam logic [1:0] CFG_START = 2'd3;
endpackage

// File: rtl/txq_regs.sv
module txq_regs #(
  parameter int TW = 6,
  parameter logic [TW-1:0] DEF_LOW   = 8,
  parameter logic [TW-1:0] DEF_HIGH  = 8,
  parameter logic [TW-1:0] DEF_CONG  = 48,
  parameter logic [TW-1:0] DEF_START = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_addr,
  input  logic [TW-1:0] cfg_wdata,
  output logic [TW-1:0] th_low,
  output logic [TW-1:0] th_high,
  output logic [TW-1:0] th_cong,
  output logic [TW-1:0] th_start
);
  import txq_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) begin
      th_low   <= DEF_LOW;
      th_high  <= DEF_HIGH;
      th_cong  <= DEF_CONG;
      th_start <= DEF_START;
    end else if (cfg_we) begin
      case (cfg_addr)
        CFG_LOW:  th_low   <= cfg_wdata;
        CFG_HIGH: th_high  <= cfg_wdata;
        CFG_CONG: th_cong  <= cfg_wdata;
        default:  th_start <= cfg_wdata;
      endcase
    end
  end

  // R9: a start-threshold write lands one cycle later
  p_cfg_start_r9: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && cfg_addr == CFG_START) |=> (th_start == $past(cfg_wdata)));
endmodule

// File: rtl/txq_store.sv
module txq_store #(
  parameter int DW = 8,
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          push_sop,
  input  logic          push_eop,
  input  logic          pop,
  output logic [DW-1:0] head_data,
  output logic          head_sop,
  output logic          head_eop,
  output logic [AW:0]   fill,
  output logic [AW:0]   frames
);
  localparam int DEPTH = 1 << AW;
  localparam int EW    = DW + 2;

  logic [EW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [EW-1:0] head;

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= {push_sop, push_eop, push_data};
  end

  assign head      = mem[rd_ptr];
  assign head_data = head[DW-1:0];
  assign head_eop  = head[DW];
  assign head_sop  = head[DW+1];

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill   <= '0;
      frames <= '0;
    end else begin
      if (push) wr_ptr <= wr_ptr + 1'b1;
      if (pop)  rd_ptr <= rd_ptr + 1'b1;
      case ({push, pop})
        2'b10:   fill <= fill + 1'b1;
        2'b01:   fill <= fill - 1'b1;
        default: fill <= fill;
      endcase
      case ({push && push_eop, pop && head_eop})
        2'b10:   frames <= frames + 1'b1;
        2'b01:   frames <= frames - 1'b1;
        default: frames <= frames;
      endcase
    end
  end

  p_no_overflow_r10: assert property (@(posedge clk) disable iff (rst)
    push |-> (fill != (AW+1)'(DEPTH)));
  p_no_underflow_r7: assert property (@(posedge clk) disable iff (rst)
    pop |-> (fill != '0));
  p_fill_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (push && pop) |=> $stable(fill));
endmodule

// File: rtl/txq_rd_ctrl.sv
module txq_rd_ctrl #(
  parameter int DW  = 8,
  parameter int AW  = 6,
  parameter int TW  = 6,
  parameter int IFG = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW:0]   fill,
  input  logic [AW:0]   frames,
  input  logic [TW-1:0] th_low,
  input  logic [TW-1:0] th_start,
  input  logic [DW-1:0] head_data,
  input  logic          head_sop,
  input  logic          head_eop,
  output logic          pop,
  output logic [DW-1:0] tx_data,
  output logic          tx_en,
  output logic          tx_err
);
  import txq_pkg::*;

  localparam int GW = $clog2(IFG);
  localparam logic [GW-1:0] GAP_LOAD = GW'(IFG - 2);

  rd_state_e     state_q, state_d;
  logic [GW-1:0] gap_q, gap_d;
  logic          en_d, err_d, last_d, tx_last;
  logic [DW-1:0] data_d;
  logic          start_ok, starving;

  assign start_ok = (frames != '0) ||
                    ((th_start != '0) && (fill >= {{(AW+1-TW){1'b0}}, th_start}));
  assign starving = (frames == '0) && (fill <= {{(AW+1-TW){1'b0}}, th_low});

  always_comb begin
    state_d = state_q;
    gap_d   = gap_q;
    pop     = 1'b0;
    en_d    = 1'b0;
    err_d   = 1'b0;
    last_d  = 1'b0;
    data_d  = '0;
    case (state_q)
      RD_IDLE: if (start_ok) state_d = RD_SEND;
      RD_SEND: begin
        en_d = 1'b1;
        if (starving) begin
          err_d   = 1'b1;
          state_d = RD_DRAIN;
        end else begin
          pop    = 1'b1;
          data_d = head_data;
          last_d = head_eop;
          if (head_eop) begin
            state_d = RD_GAP;
            gap_d   = GAP_LOAD;
          end
        end
      end
      RD_DRAIN: if (fill != '0) begin
        pop = 1'b1;
        if (head_eop) begin
          state_d = RD_GAP;
          gap_d   = GAP_LOAD;
        end
      end
      default: begin
        if (gap_q == '0) state_d = RD_IDLE;
        else             gap_d   = gap_q - 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= RD_IDLE;
      gap_q   <= '0;
      tx_en   <= 1'b0;
      tx_err  <= 1'b0;
      tx_last <= 1'b0;
      tx_data <= '0;
    end else begin
      state_q <= state_d;
      gap_q   <= gap_d;
      tx_en   <= en_d;
      tx_err  <= err_d;
      tx_last <= last_d;
      tx_data <= data_d;
    end
  end

  p_frame_head_r6: assert property (@(posedge clk) disable iff (rst)
    (state_q == RD_IDLE && start_ok) |-> head_sop);
  p_err_marks_r7: assert property (@(posedge clk) disable iff (rst)
    tx_err |-> tx_en);
  p_err_alone_r7: assert property (@(posedge clk) disable iff (rst)
    tx_err |=> !tx_en);
  p_no_hole_r6: assert property (@(posedge clk) disable iff (rst)
    (tx_en && !tx_err && !tx_last) |=> tx_en);
  p_gap_after_end_r8: assert property (@(posedge clk) disable iff (rst)
    (tx_en && tx_last) |=> !tx_en);
endmodule

// File: rtl/txq_thresh_fifo.sv
module txq_thresh_fifo #(
  parameter int DW  = 8,
  parameter int AW  = 6,
  parameter int TW  = 6,
  parameter int IFG = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  input  logic          in_sop,
  input  logic          in_eop,
  output logic          in_ready,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_addr,
  input  logic [TW-1:0] cfg_wdata,
  output logic [DW-1:0] tx_data,
  output logic          tx_en,
  output logic          tx_err,
  output logic          flag_aempty,
  output logic          flag_afull,
  output logic          flag_sempty
);
  localparam int DEPTH = 1 << AW;
  localparam int PADW  = AW + 1 - TW;

  logic [TW-1:0] th_low, th_high, th_cong, th_start;
  logic [AW:0]   fill, frames, free_cnt;
  logic [DW-1:0] head_data;
  logic          head_sop, head_eop, push, pop;

  txq_regs #(.TW(TW)) u_regs (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .th_low(th_low), .th_high(th_high), .th_cong(th_cong), .th_start(th_start)
  );

  txq_store #(.DW(DW), .AW(AW)) u_store (
    .clk(clk), .rst(rst), .push(push), .push_data(in_data), .push_sop(in_sop),
    .push_eop(in_eop), .pop(pop), .head_data(head_data), .head_sop(head_sop),
    .head_eop(head_eop), .fill(fill), .frames(frames)
  );

  txq_rd_ctrl #(.DW(DW), .AW(AW), .TW(TW), .IFG(IFG)) u_rd (
    .clk(clk), .rst(rst), .fill(fill), .frames(frames), .th_low(th_low),
    .th_start(th_start), .head_data(head_data), .head_sop(head_sop),
    .head_eop(head_eop), .pop(pop), .tx_data(tx_data), .tx_en(tx_en), .tx_err(tx_err)
  );

  assign free_cnt    = (AW+1)'(DEPTH) - fill;
  assign flag_afull  = free_cnt <= {{PADW{1'b0}}, th_high};
  assign in_ready    = !flag_afull;
  assign push        = in_valid && in_ready;
  assign flag_aempty = fill <= {{PADW{1'b0}}, th_low};
  assign flag_sempty = fill <  {{PADW{1'b0}}, th_cong};

  p_refuse_r2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_ready && !pop) |=> $stable(fill));
endmodule

// File: tb/sim_txq_thresh_fifo.sv
`timescale 1ns/1ps
module sim_txq_thresh_fifo;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0, cfg_we = 1'b0;
  logic [7:0] in_data = '0;
  logic [1:0] cfg_addr = '0;
  logic [5:0] cfg_wdata = '0;
  logic in_ready, tx_en, tx_err, flag_aempty, flag_afull, flag_sempty;
  logic [7:0] tx_data;

  int errors = 0, checks = 0, fill_m = 0;
  bit done = 1'b0;
  int cyc = 0, cap_n = 0;
  int cap_d [0:511];
  int cap_e [0:511];
  int cap_c [0:511];

  always #4 clk = ~clk;

  txq_thresh_fifo u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data), .in_sop(in_sop),
    .in_eop(in_eop), .in_ready(in_ready), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .tx_data(tx_data), .tx_en(tx_en), .tx_err(tx_err),
    .flag_aempty(flag_aempty), .flag_afull(flag_afull), .flag_sempty(flag_sempty)
  );

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (tx_en && cap_n < 512) begin
      cap_d[cap_n] <= int'(tx_data);
      cap_e[cap_n] <= int'(tx_err);
      cap_c[cap_n] <= cyc;
      cap_n <= cap_n + 1;
    end
  end

  // {fill[6:0], aempty, afull, sempty, ready} at default thresholds 8/8/48
  localparam logic [10:0] VEC [0:6] = '{
    {7'd0,  4'b1011}, {7'd8,  4'b1011}, {7'd9,  4'b0011}, {7'd47, 4'b0011},
    {7'd48, 4'b0001}, {7'd55, 4'b0001}, {7'd56, 4'b0100}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push(input int d, input bit s, input bit e);
    in_valid = 1'b1; in_data = d[7:0]; in_sop = s; in_eop = e;
    @(negedge clk);
    in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
  endtask

  task automatic cfg(input logic [1:0] a, input logic [5:0] v);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic frame_ok(input int b, input int n, input int base_val, input string tag);
    int bad = 0;
    for (int i = 0; i < n; i++)
      if (cap_d[b+i] != ((base_val + i) & 255) || cap_e[b+i] != 0) bad++;
    chk(bad == 0, tag, bad, 0);
  endtask

  initial begin
    repeat (25000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int b;
    idle(3);
    rst = 1'b0;
    // R11 reset state
    chk(in_ready == 1'b1, "R11 ready after reset", in_ready, 1);
    chk(tx_en == 1'b0, "R11 tx_en after reset", tx_en, 0);
    chk(flag_aempty == 1'b1, "R11/R1 aempty after reset", flag_aempty, 1);
    chk(flag_afull == 1'b0, "R11/R2 afull after reset", flag_afull, 0);
    chk(flag_sempty == 1'b1, "R11/R3 sempty after reset", flag_sempty, 1);

    // Vector walk: start threshold 63 keeps the reader idle (R9, R4)
    cfg(2'd3, 6'd63);
    for (int v = 0; v < 7; v++) begin
      while (fill_m < int'(VEC[v][10:4])) begin
        push(fill_m, fill_m == 0, 1'b0);
        fill_m++;
      end
      chk(flag_aempty == VEC[v][3], $sformatf("R1 aempty at fill %0d", fill_m), flag_aempty, VEC[v][3]);
      chk(flag_afull  == VEC[v][2], $sformatf("R2 afull at fill %0d", fill_m), flag_afull, VEC[v][2]);
      chk(flag_sempty == VEC[v][1], $sformatf("R3 sempty at fill %0d", fill_m), flag_sempty, VEC[v][1]);
      chk(in_ready    == VEC[v][0], $sformatf("R2 ready at fill %0d", fill_m), in_ready, VEC[v][0]);
    end
    chk(cap_n == 0, "R4 no start below start level", cap_n, 0);
    // R2: offered bytes while not ready are dropped
    in_valid = 1'b1; in_data = 8'hEE;
    idle(4);
    in_valid = 1'b0;
    chk(flag_afull == 1'b1, "R2 afull holds after refused writes", flag_afull, 1);
    cfg(2'd1, 6'd0);
    chk(in_ready == 1'b1, "R9/R2 ready after high-water lowered", in_ready, 1);
    push(56, 1'b0, 1'b1);
    idle(80);
    chk(cap_n == 57, "R2/R6 frame length excludes refused bytes", cap_n, 57);
    frame_ok(0, 57, 0, "R6 frame bytes in order");

    // Store-and-forward (R5) and exact gap (R8)
    cfg(2'd1, 6'd8);
    cfg(2'd3, 6'd0);
    b = cap_n;
    for (int i = 0; i < 20; i++) push(8'h10 + i, i == 0, 1'b0);
    idle(10);
    chk(cap_n == b, "R5 no start before end byte", cap_n - b, 0);
    push(8'h10 + 20, 1'b0, 1'b1);
    for (int i = 0; i < 10; i++) push(8'hC0 + i, i == 0, i == 9);
    idle(80);
    chk(cap_n - b == 31, "R5 two frames forwarded", cap_n - b, 31);
    frame_ok(b, 21, 8'h10, "R5 first frame bytes");
    frame_ok(b + 21, 10, 8'hC0, "R6 second frame bytes");
    chk(cap_c[b+21] - cap_c[b+20] - 1 == 12, "R8 gap between frames",
        cap_c[b+21] - cap_c[b+20] - 1, 12);

    // Start-level gating with concurrent write/read (R4, R10)
    cfg(2'd3, 6'd16);
    b = cap_n;
    for (int i = 0; i < 15; i++) push(8'h20 + i, i == 0, 1'b0);
    idle(5);
    chk(cap_n == b, "R4 held below start level", cap_n - b, 0);
    for (int i = 15; i < 40; i++) push(8'h20 + i, 1'b0, i == 39);
    idle(70);
    chk(cap_n - b == 40, "R4 frame sent after start level", cap_n - b, 40);
    frame_ok(b, 40, 8'h20, "R10 streaming push+pop keeps frame intact");

    // Underflow abort (R7)
    b = cap_n;
    for (int i = 0; i < 20; i++) push(8'h40 + i, i == 0, 1'b0);
    idle(30);
    chk(cap_n - b == 13, "R7 bytes up to abort marker", cap_n - b, 13);
    frame_ok(b, 12, 8'h40, "R7 bytes before abort");
    chk(cap_e[b+12] == 1, "R7 error marker", cap_e[b+12], 1);
    for (int i = 0; i < 5; i++) push(8'h60 + i, 1'b0, i == 4);
    idle(5);
    for (int i = 0; i < 20; i++) push(8'h80 + i, i == 0, i == 19);
    idle(60);
    chk(cap_n - b == 33, "R7 remainder discarded", cap_n - b, 33);
    frame_ok(b + 13, 20, 8'h80, "R7 next frame clean");
    chk(cap_c[b+13] - cap_c[b+12] - 1 >= 12, "R8 gap after abort",
        cap_c[b+13] - cap_c[b+12] - 1, 12);

    // Reset restores thresholds (R11)
    cfg(2'd0, 6'd20);
    for (int i = 0; i < 3; i++) push(i, i == 0, 1'b0);
    rst = 1'b1;
    idle(2);
    rst = 1'b0;
    chk(flag_aempty == 1'b1, "R11 queue emptied", flag_aempty, 1);
    chk(tx_en == 1'b0, "R11 no output after reset", tx_en, 0);
    b = cap_n;
    for (int i = 0; i < 9; i++) push(i, i == 0, 1'b0);
    chk(flag_aempty == 1'b0, "R11 low-water back to 8", flag_aempty, 0);
    idle(5);
    chk(cap_n == b, "R11 start level back to 16", cap_n - b, 0);

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule